// File: doc/BRIEF.md
# Thread-to-Class Mapper with Route-ID Priority Override

This block sits on the bridge between a shared-memory interconnect and a memory controller. For each transaction it takes the traffic thread and the read/write direction and picks one of five memory service classes from a small programmable table. Thread 2 carries urgent traffic and thread 0 carries background traffic. Any other thread value is handled with the thread-0 tables. Each thread has its own table entry for reads and another for writes.

Each transaction also carries a bus priority. When override is enabled and the transaction's route ID lies inside a programmable inclusive window, a programmed priority replaces the bus priority. The two variable classes carry this effective priority. The three fixed classes carry a constant priority. The class and its priority are registered, so they appear one cycle after the request. The tables are loaded through a simple write-only register port.

Top module: `tcm_class_mapper`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_class`/`out_prio` are 0. The tables reset to: thread-0 read = LO_RD, thread-0 write = NRM_WR, thread-2 read = HI_RD, thread-2 write = VAR_WR. The override is disabled with window [0,0] and override priority 0.
- R2: `out_valid` equals `req_valid` of the previous cycle. `out_class` and `out_prio` for a request appear in that same next cycle.
- R3: A request on thread 2 uses the thread-2 entries (cfg address 2 = read, 3 = write). Any other thread value uses the thread-0 entries (address 0 = read, 1 = write). Class codes are 0 HI_RD, 1 VAR_RD, 2 LO_RD, 3 NRM_WR, 4 VAR_WR.
- R4: A read entry written with code 0, 1 or 2 stores that code. Any other code is stored as LO_RD (2), so reads always get a read class.
- R5: A write entry written with code 4 stores VAR_WR. Any other code is stored as NRM_WR (3), so writes always get a write class.
- R6: The cfg control register is at address 4, with bit 0 = enable and bits 3:1 = override priority. The window bounds are at address 5 (low) and address 6 (high). When enable is 1 and low <= route ID <= high (inclusive), the effective priority is the override priority.
- R7: When enable is 0, or the route ID is outside the window (including any ID when low > high), the effective priority is the bus priority.
- R8: VAR_RD and VAR_WR output the effective priority. HI_RD outputs priority 7, LO_RD outputs 0 and NRM_WR outputs 4, whatever the bus or override priority.
- R9: A cfg write in the same cycle as a request does not affect that request's result. It applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transaction present this cycle |
| req_thread | input | 2 | Traffic thread number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_route_id | input | 12 | Source route ID |
| req_bus_prio | input | 3 | Priority carried on the bus |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 12 | Register write data |
| out_valid | output | 1 | Registered result valid |
| out_class | output | 3 | Resolved service class code |
| out_prio | output | 3 | Priority attached to the class |

## Verification
The hardest case to reach is a cfg write that lands in the same cycle as a request to the entry being changed. The bench drives the strobe and the request on the same falling edge, expects the old mapping on that request and the new mapping on the next one. It also reaches the window boundaries: IDs exactly equal to each bound and one past each. An inverted window is tried to confirm that it never matches.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  typedef enum logic [2:0] {
    HI_RD  = 3'd0,
    VAR_RD = 3'd1,
    LO_RD  = 3'd2,
    NRM_WR = 3'd3,
    VAR_WR = 3'd4
  } svc_class_e;

  localparam int CLS_W  = 3;
  localparam int N_SLOT = 4;

  // Coerce a programmed code into the legal set for its slot direction.
  function automatic svc_class_e sanitize_code(input logic wr_slot, input logic [CLS_W-1:0] code);
    if (wr_slot) return (code == 3'd4) ? VAR_WR : NRM_WR;
    return (code <= 3'd2) ? svc_class_e'(code) : LO_RD;
  endfunction

  // Reset value of each table slot, index = {thread_hi, is_write}.
  function automatic svc_class_e slot_default(input int idx);
    case (idx)
      0:       return LO_RD;
      1:       return NRM_WR;
      2:       return HI_RD;
      default: return VAR_WR;
    endcase
  endfunction

  function automatic logic is_variable(input svc_class_e c);
    return (c == VAR_RD) || (c == VAR_WR);
  endfunction

endpackage

// File: rtl/tcm_cfg_regs.sv
module tcm_cfg_regs
  import tcm_pkg::*;
#(
  parameter int ROUTE_W = 12,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [ROUTE_W-1:0]      cfg_wdata,
  output logic [N_SLOT*CLS_W-1:0] map_flat,
  output logic                    ovr_en,
  output logic [PRIO_W-1:0]       ovr_prio,
  output logic [ROUTE_W-1:0]      rng_lo,
  output logic [ROUTE_W-1:0]      rng_hi
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(N_SLOT);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(N_SLOT + 1);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(N_SLOT + 2);

  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    localparam logic WR_SLOT = logic'(i % 2);
    svc_class_e slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q <= slot_default(i);
      else if (cfg_we && cfg_addr == ADDR_W'(i))
        slot_q <= sanitize_code(WR_SLOT, cfg_wdata[CLS_W-1:0]);
    end
    assign map_flat[i*CLS_W +: CLS_W] = slot_q;

    if (WR_SLOT) begin : g_wr_chk
      a_r5_wr_slot_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == NRM_WR) || (slot_q == VAR_WR));
    end else begin : g_rd_chk
      a_r4_rd_slot_legal: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= LO_RD);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_en   <= 1'b0;
      ovr_prio <= '0;
      rng_lo   <= '0;
      rng_hi   <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == A_CTRL) begin
        ovr_en   <= cfg_wdata[0];
        ovr_prio <= cfg_wdata[PRIO_W:1];
      end
      if (cfg_addr == A_LO) rng_lo <= cfg_wdata;
      if (cfg_addr == A_HI) rng_hi <= cfg_wdata;
    end
  end

endmodule

// File: rtl/tcm_override.sv
module tcm_override #(
  parameter int ROUTE_W = 12,
  parameter int PRIO_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ROUTE_W-1:0] route_id,
  input  logic [PRIO_W-1:0]  bus_prio,
  input  logic               ovr_en,
  input  logic [PRIO_W-1:0]  ovr_prio,
  input  logic [ROUTE_W-1:0] rng_lo,
  input  logic [ROUTE_W-1:0] rng_hi,
  output logic               ovr_hit,
  output logic [PRIO_W-1:0]  eff_prio
);
  function automatic logic in_window(input logic [ROUTE_W-1:0] id,
                                     input logic [ROUTE_W-1:0] lo,
                                     input logic [ROUTE_W-1:0] hi);
    return (id >= lo) && (id <= hi);
  endfunction

  assign ovr_hit  = ovr_en && in_window(route_id, rng_lo, rng_hi);
  assign eff_prio = ovr_hit ? ovr_prio : bus_prio;

  a_r7_disabled_passes_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_en |-> (eff_prio == bus_prio));
  a_r7_inverted_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (rng_lo > rng_hi) |-> !ovr_hit);
  a_r6_hit_takes_override: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_hit |-> (eff_prio == ovr_prio));

endmodule

// File: rtl/tcm_class_sel.sv
module tcm_class_sel
  import tcm_pkg::*;
#(
  parameter int THREAD_W  = 2,
  parameter int PRIO_W    = 3,
  parameter int HI_THREAD = 2
) (
  input  logic [THREAD_W-1:0]     thread,
  input  logic                    is_write,
  input  logic [N_SLOT*CLS_W-1:0] map_flat,
  input  logic [PRIO_W-1:0]       eff_prio,
  output svc_class_e              cls,
  output logic [PRIO_W-1:0]       prio
);
  localparam logic [PRIO_W-1:0] P_TOP = '1;
  localparam logic [PRIO_W-1:0] P_MID = PRIO_W'(1) << (PRIO_W - 1);

  function automatic logic [PRIO_W-1:0] class_prio(input svc_class_e c,
                                                   input logic [PRIO_W-1:0] ep);
    case (c)
      HI_RD:   return P_TOP;
      LO_RD:   return '0;
      NRM_WR:  return P_MID;
      default: return ep;
    endcase
  endfunction

  logic       thread_hi;
  logic [1:0] slot;

  assign thread_hi = (thread == THREAD_W'(HI_THREAD));
  assign slot      = {thread_hi, is_write};
  assign cls       = svc_class_e'(map_flat[slot*CLS_W +: CLS_W]);
  assign prio      = class_prio(cls, eff_prio);

endmodule

// File: rtl/tcm_class_mapper.sv
module tcm_class_mapper
  import tcm_pkg::*;
#(
  parameter int ROUTE_W   = 12,
  parameter int PRIO_W    = 3,
  parameter int THREAD_W  = 2,
  parameter int ADDR_W    = 3,
  parameter int HI_THREAD = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [THREAD_W-1:0] req_thread,
  input  logic                req_write,
  input  logic [ROUTE_W-1:0]  req_route_id,
  input  logic [PRIO_W-1:0]   req_bus_prio,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [ROUTE_W-1:0]  cfg_wdata,
  output logic                out_valid,
  output logic [CLS_W-1:0]    out_class,
  output logic [PRIO_W-1:0]   out_prio
);
  localparam logic [PRIO_W-1:0] P_TOP = '1;

  logic [N_SLOT*CLS_W-1:0] map_flat;
  logic                    ovr_en;
  logic [PRIO_W-1:0]       ovr_prio;
  logic [ROUTE_W-1:0]      rng_lo, rng_hi;
  logic                    ovr_hit;
  logic [PRIO_W-1:0]       eff_prio;
  svc_class_e              sel_cls;
  logic [PRIO_W-1:0]       sel_prio;
  logic                    wr_q;

  tcm_cfg_regs #(.ROUTE_W(ROUTE_W), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .map_flat(map_flat), .ovr_en(ovr_en),
    .ovr_prio(ovr_prio), .rng_lo(rng_lo), .rng_hi(rng_hi)
  );

  tcm_override #(.ROUTE_W(ROUTE_W), .PRIO_W(PRIO_W)) u_ovr (
    .clk(clk), .rst_n(rst_n), .route_id(req_route_id), .bus_prio(req_bus_prio),
    .ovr_en(ovr_en), .ovr_prio(ovr_prio), .rng_lo(rng_lo), .rng_hi(rng_hi),
    .ovr_hit(ovr_hit), .eff_prio(eff_prio)
  );

  tcm_class_sel #(.THREAD_W(THREAD_W), .PRIO_W(PRIO_W), .HI_THREAD(HI_THREAD)) u_sel (
    .thread(req_thread), .is_write(req_write), .map_flat(map_flat),
    .eff_prio(eff_prio), .cls(sel_cls), .prio(sel_prio)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_class <= '0;
      out_prio  <= '0;
      wr_q      <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_class <= sel_cls;
        out_prio  <= sel_prio;
        wr_q      <= req_write;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  a_r5_write_gets_write_class: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wr_q) |-> (out_class == NRM_WR || out_class == VAR_WR));
  a_r4_read_gets_read_class: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wr_q) |-> (out_class <= LO_RD));
  a_r8_high_read_top_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == HI_RD) |-> (out_prio == P_TOP));
  a_r8_low_read_zero_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == LO_RD) |-> (out_prio == '0));

endmodule

// File: tb/tcm_class_mapper_tb.sv
`timescale 1ns/1ps
module tcm_class_mapper_tb;
  localparam int HI_RD = 0, VAR_RD = 1, LO_RD = 2, NRM_WR = 3, VAR_WR = 4;

  logic        clk = 0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_thread;
  logic        req_write;
  logic [11:0] req_route_id;
  logic [2:0]  req_bus_prio;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [11:0] cfg_wdata;
  logic        out_valid;
  logic [2:0]  out_class;
  logic [2:0]  out_prio;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tcm_class_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_thread(req_thread),
    .req_write(req_write), .req_route_id(req_route_id), .req_bus_prio(req_bus_prio),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_class(out_class), .out_prio(out_prio)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [11:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic issue(input logic [1:0] th, input logic wr, input logic [11:0] id,
                       input logic [2:0] bp, input int e_cls, input int e_pri,
                       input string req);
    @(negedge clk);
    req_valid = 1; req_thread = th; req_write = wr; req_route_id = id; req_bus_prio = bp;
    @(posedge clk); #1;
    req_valid = 0;
    chk(req, out_valid, 1);
    chk(req, out_class, e_cls);
    chk(req, out_prio, e_pri);
  endtask

  task automatic t_reset;
    chk("R1 valid", out_valid, 0);
    chk("R1 class", out_class, 0);
    chk("R1 prio", out_prio, 0);
    issue(0, 0, 12'h005, 4, LO_RD, 0, "R1 t0 read default");
    issue(0, 1, 12'h005, 4, NRM_WR, 4, "R1 t0 write default");
    issue(2, 0, 12'h005, 1, HI_RD, 7, "R1 t2 read default");
    issue(2, 1, 12'h000, 5, VAR_WR, 5, "R1 t2 write default, no override");
  endtask

  task automatic t_timing;
    @(negedge clk); @(negedge clk);
    chk("R2 idle", out_valid, 0);
    req_valid = 1; req_thread = 2; req_write = 0; req_route_id = 0; req_bus_prio = 0;
    #2 chk("R2 not same cycle", out_valid, 0);
    @(posedge clk); #1;
    req_valid = 0;
    chk("R2 next cycle valid", out_valid, 1);
    chk("R2 next cycle class", out_class, HI_RD);
    @(posedge clk); #1;
    chk("R2 drops after", out_valid, 0);
  endtask

  task automatic t_thread;
    issue(1, 0, 12'h010, 3, LO_RD, 0, "R3 thread1 uses t0");
    cfg_write(0, VAR_RD);
    issue(3, 0, 12'h010, 6, VAR_RD, 6, "R3 thread3 uses t0");
    issue(2, 0, 12'h010, 6, HI_RD, 7, "R3 thread2 own table");
  endtask

  task automatic t_read_sanitize;
    cfg_write(2, 3);
    issue(2, 0, 12'h020, 5, LO_RD, 0, "R4 write code on read slot");
    cfg_write(2, 7);
    issue(2, 0, 12'h020, 5, LO_RD, 0, "R4 illegal code on read slot");
    cfg_write(2, VAR_RD);
    issue(2, 0, 12'h020, 5, VAR_RD, 5, "R4 legal read code");
  endtask

  task automatic t_write_sanitize;
    cfg_write(1, 0);
    issue(0, 1, 12'h030, 2, NRM_WR, 4, "R5 read code on write slot");
    cfg_write(1, 1);
    issue(0, 1, 12'h030, 2, NRM_WR, 4, "R5 var-read code on write slot");
    cfg_write(1, VAR_WR);
    issue(0, 1, 12'h030, 2, VAR_WR, 2, "R5 legal write code");
  endtask

  task automatic t_override;
    cfg_write(5, 12'h100);
    cfg_write(6, 12'h1FF);
    cfg_write(4, 12'd13);   // enable, prio 6
    issue(2, 1, 12'h100, 1, VAR_WR, 6, "R6 low bound hit");
    issue(2, 1, 12'h1FF, 1, VAR_WR, 6, "R6 high bound hit");
    issue(0, 0, 12'h150, 2, VAR_RD, 6, "R6 read variable class override");
    issue(2, 1, 12'h200, 1, VAR_WR, 1, "R7 above window");
    issue(2, 1, 12'h0FF, 1, VAR_WR, 1, "R7 below window");
    cfg_write(2, HI_RD);
    issue(2, 0, 12'h150, 0, HI_RD, 7, "R8 fixed high read under override");
    cfg_write(1, NRM_WR);
    issue(0, 1, 12'h150, 0, NRM_WR, 4, "R8 fixed normal write under override");
    cfg_write(1, VAR_WR);
  endtask

  task automatic t_disabled;
    cfg_write(4, 12'd12);   // prio 6, enable 0
    issue(2, 1, 12'h150, 3, VAR_WR, 3, "R7 disabled in window");
    cfg_write(5, 12'h300);
    cfg_write(6, 12'h200);
    cfg_write(4, 12'd13);
    issue(2, 1, 12'h250, 3, VAR_WR, 3, "R7 inverted window");
    issue(2, 1, 12'h300, 2, VAR_WR, 2, "R7 inverted window at low bound");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3; cfg_wdata = NRM_WR;
    req_valid = 1; req_thread = 2; req_write = 1; req_route_id = 12'h010; req_bus_prio = 5;
    @(posedge clk); #1;
    cfg_we = 0; req_valid = 0;
    chk("R9 old mapping class", out_class, VAR_WR);
    chk("R9 old mapping prio", out_prio, 5);
    issue(2, 1, 12'h010, 5, NRM_WR, 4, "R9 new mapping next request");
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_thread = 0; req_write = 0; req_route_id = 0;
    req_bus_prio = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_timing();
    t_thread();
    t_read_sanitize();
    t_write_sanitize();
    t_override();
    t_disabled();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule